// File: doc/BRIEF.md
# Byte-Serial CRC-32 Engine

This block folds a stream of bytes into a 32-bit cyclic redundancy check, one byte per clock. It uses the generator x^32 + x^29 + x^18 + x^14 + x^3 + 1 (0x20044009 written in normal notation). Each byte enters the most significant bit first. There is no reflection of the input or the result, and no final inversion. This is not the common Ethernet CRC.

A caller begins a message by loading a seed, normally all-ones. It then presents bytes with a valid strobe and reads the running remainder from a registered output, which changes on the clock edge that accepts a byte. The generator is fixed when the design is elaborated.

Each cycle a small decoder picks one of three actions: HOLD, SEED or FOLD. HOLD applies when neither strobe is high and keeps the register as it is. SEED applies whenever a seed load is requested, whether or not a byte is present, and replaces the register with the seed. FOLD applies when only a byte is valid and writes the next remainder into the register. The register takes each action on the following clock edge.

Top module: `crc32_byte_engine`

## Requirements
- R1: After reset is released, and before any seed or byte is applied, `crc_out` reads 0xFFFFFFFF.
- R2: When `seed_load` is high at a clock edge, `crc_out` equals `seed_value` after that edge.
- R3: When `byte_valid` is high and `seed_load` is low at a clock edge, the new `crc_out` is formed by XORing `byte_data` into bits 31:24 of the old value and then doing eight steps. In each step, if bit 31 is 1 the value is shifted left by one and XORed with 0x20044009; otherwise it is only shifted left by one. No reflection and no final XOR are applied.
- R4: When `seed_load` and `byte_valid` are both low at a clock edge, `crc_out` keeps its value.
- R5: When `seed_load` and `byte_valid` are high together, the seed wins and the byte is discarded.
- R6: Seeding with 0xFFFFFFFF and then folding the bytes 0x01, 0x02, 0x03, 0x04 gives `crc_out` = 0xF33CB7D3.
- R7: Bytes can be accepted on consecutive clock edges with no idle cycle between them, and each one is folded in order.
- R8: While `byte_valid` is low, the value on `byte_data` has no effect on `crc_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset; sets the register to all-ones |
| seed_load | input | 1 | Load `seed_value` into the register |
| seed_value | input | 32 | Starting remainder for a new message |
| byte_valid | input | 1 | `byte_data` is to be folded in this cycle |
| byte_data | input | 8 | Message byte, most significant bit processed first |
| crc_out | output | 32 | Registered running remainder |

## Verification
Any fault in the register or in the fold logic shows up on `crc_out` on the clock edge that follows the faulty cycle. Because every later byte is folded on top of the corrupted remainder, the error stays visible from that point on. A wrong generator bit, a wrong bit order, or a missing feedback term therefore breaks the known four-byte result and the back-to-back stream. A wrong choice of action shows up one cycle late as a remainder that changed when it should have held, or that failed to take the seed.

// File: rtl/crc32_pkg.sv
package crc32_pkg;

    localparam int unsigned CRC_W  = 32;
    localparam int unsigned BYTE_W = 8;

    localparam logic [CRC_W-1:0] CRC_RESET_VALUE = '1;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SEED = 2'd1,
        ACT_FOLD = 2'd2
    } crc_action_t;

endpackage

// File: rtl/crc32_byte_fold.sv
module crc32_byte_fold #(
    parameter int unsigned          WIDTH  = 32,
    parameter int unsigned          DATA_W = 8,
    parameter logic [WIDTH-1:0]     POLY   = 32'h2004_4009
) (
    input  logic [WIDTH-1:0]  rem_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [WIDTH-1:0]  rem_next
);

    localparam int unsigned PAD_W = WIDTH - DATA_W;

    logic [WIDTH-1:0] stage [DATA_W+1];

    assign stage[0] = rem_in ^ {data_in, {PAD_W{1'b0}}};

    for (genvar k = 0; k < DATA_W; k++) begin : g_bit
        assign stage[k+1] = stage[k][WIDTH-1]
                            ? ({stage[k][WIDTH-2:0], 1'b0} ^ POLY)
                            :  {stage[k][WIDTH-2:0], 1'b0};
    end

    assign rem_next = stage[DATA_W];

endmodule

// File: rtl/crc32_ctrl.sv
module crc32_ctrl
    import crc32_pkg::*;
(
    input  logic        seed_load,
    input  logic        byte_valid,
    output crc_action_t action
);

    always_comb begin
        if (seed_load)
            action = ACT_SEED;
        else if (byte_valid)
            action = ACT_FOLD;
        else
            action = ACT_HOLD;
    end

    // R5
    always_comb begin
        seed_wins_chk: assert (!(seed_load && byte_valid) || action == ACT_SEED);
    end

endmodule

// File: rtl/crc32_state_reg.sv
module crc32_state_reg
    import crc32_pkg::*;
#(
    parameter int unsigned       WIDTH = 32,
    parameter logic [WIDTH-1:0]  INIT  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  crc_action_t      action,
    input  logic [WIDTH-1:0] seed,
    input  logic [WIDTH-1:0] folded,
    output logic [WIDTH-1:0] rem_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= INIT;
        end else begin
            unique case (action)
                ACT_SEED: rem_q <= seed;
                ACT_FOLD: rem_q <= folded;
                ACT_HOLD: rem_q <= rem_q;
                default:  rem_q <= rem_q;
            endcase
        end
    end

endmodule

// File: rtl/crc32_byte_engine.sv
module crc32_byte_engine
    import crc32_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 32'h2004_4009
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_load,
    input  logic [CRC_W-1:0]  seed_value,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [CRC_W-1:0]  crc_out
);

    crc_action_t      action;
    logic [CRC_W-1:0] folded;

    crc32_ctrl u_ctrl (
        .seed_load  (seed_load),
        .byte_valid (byte_valid),
        .action     (action)
    );

    crc32_byte_fold #(
        .WIDTH  (CRC_W),
        .DATA_W (BYTE_W),
        .POLY   (POLY)
    ) u_fold (
        .rem_in   (crc_out),
        .data_in  (byte_data),
        .rem_next (folded)
    );

    crc32_state_reg #(
        .WIDTH (CRC_W),
        .INIT  (CRC_RESET_VALUE)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .action (action),
        .seed   (seed_value),
        .folded (folded),
        .rem_q  (crc_out)
    );

    // R1
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> crc_out == CRC_RESET_VALUE);

    // R2
    seed_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> crc_out == $past(seed_value));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seed_load && !byte_valid) |=> $stable(crc_out));

    // R5
    seed_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_load && byte_valid) |=> crc_out == $past(seed_value));

endmodule

// File: tb/tb_crc32_byte_engine.sv
`timescale 1ns/1ps
module tb_crc32_byte_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seed_load = 1'b0;
    logic [31:0] seed_value = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic [31:0] crc_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [31:0] model = 32'hFFFF_FFFF;

    always #2.5 clk = ~clk;

    crc32_byte_engine dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .seed_load  (seed_load),
        .seed_value (seed_value),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .crc_out    (crc_out)
    );

    function automatic logic [31:0] ref_fold(logic [31:0] c, logic [7:0] b);
        logic [31:0] r;
        r = c ^ {b, 24'h0};
        for (int i = 0; i < 8; i++)
            r = r[31] ? ((r << 1) ^ 32'h2004_4009) : (r << 1);
        return r;
    endfunction

    task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: crc_out=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic drive(logic sl, logic [31:0] sv, logic bv, logic [7:0] bd, string tag);
        item_t it;
        @(negedge clk);
        seed_load  = sl;
        seed_value = sv;
        byte_valid = bv;
        byte_data  = bd;
        if (sl)      model = sv;
        else if (bv) model = ref_fold(model, bd);
        it.exp = model;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares one expected item per accepted edge
    always @(posedge clk) begin
        #1;
        if (rst_n && sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(crc_out, it.exp, it.tag);
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #50000;
        errors++;
        $display("FAIL watchdog: crc_out=%08h expected=completion", crc_out);
        finish_run();
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(crc_out, 32'hFFFF_FFFF, "R1 reset value");

        // R8: junk on byte_data while idle
        drive(1'b0, 32'h1234_5678, 1'b0, 8'hA5, "R8 data ignored while idle");
        drive(1'b0, 32'h0,         1'b0, 8'h3C, "R8 data ignored while idle");

        // R6: known vector
        drive(1'b1, 32'hFFFF_FFFF, 1'b0, 8'h00, "R2 seed all-ones");
        drive(1'b0, 32'h0, 1'b1, 8'h01, "R3 fold byte 01");
        drive(1'b0, 32'h0, 1'b1, 8'h02, "R7 fold byte 02");
        drive(1'b0, 32'h0, 1'b1, 8'h03, "R7 fold byte 03");
        drive(1'b0, 32'h0, 1'b1, 8'h04, "R6 known vector");
        @(negedge clk);
        byte_valid = 1'b0;
        seed_load  = 1'b0;
        #0;
        if (model !== 32'hF33C_B7D3) begin
            errors++;
            $display("FAIL R6 model: value=%08h expected=f33cb7d3", model);
        end
        checks++;

        // R4: hold with changing data
        drive(1'b0, 32'hDEAD_BEEF, 1'b0, 8'hFF, "R4 hold");
        drive(1'b0, 32'h0,         1'b0, 8'h81, "R4 hold");

        // R5: seed and byte together
        drive(1'b1, 32'h0BAD_F00D, 1'b1, 8'h77, "R5 seed priority");
        drive(1'b0, 32'h0, 1'b1, 8'h5A, "R3 fold after seed");

        // R3: zero seed, zero byte stays zero; single high bit feeds back
        drive(1'b1, 32'h0, 1'b0, 8'h00, "R2 seed zero");
        drive(1'b0, 32'h0, 1'b1, 8'h00, "R3 zero fold");
        drive(1'b0, 32'h0, 1'b1, 8'h80, "R3 single bit fold");

        // R7: long back-to-back stream with mid-stream reseed
        drive(1'b1, 32'hFFFF_FFFF, 1'b0, 8'h00, "R2 reseed");
        lf = 8'h1D;
        for (int n = 0; n < 40; n++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (n == 20)
                drive(1'b1, 32'h8000_0001, 1'b0, lf, "R2 mid-stream reseed");
            else if (n % 9 == 8)
                drive(1'b0, 32'h0, 1'b0, lf, "R8 gap in stream");
            else
                drive(1'b0, 32'h0, 1'b1, lf, "R7 back-to-back fold");
        end
        drive(1'b0, 32'h0, 1'b0, 8'h00, "R4 final hold");

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule